// File: doc/BRIEF.md
# Serial Command Receiver with Register Select

This block takes command and data bytes from a host over a write-only serial link. The link has four lines: an active-low select, a serial clock, a serial data line and a register-select line. While the select is low, the block shifts in one bit on each rising edge of the serial clock, most significant bit first. When the select goes high again, the block hands one parallel byte to the command engine. The byte is tagged as an instruction or as RAM data, depending on the register-select level captured when the select went low. A one-cycle strobe marks each delivered byte. There is no backpressure.

All four serial lines pass through two-flop synchronisers into the system clock, and every edge is detected in that domain. The system clock must run at least four times faster than the serial clock. A byte is committed on the closing edge of the select, not after a fixed bit count. When more than eight bits arrive in one select window, only the last eight are kept. A window with fewer than eight clocks is dropped.

A three-state machine controls the receiver:

- ST_IDLE waits for the select to fall (transition "open") and then moves to ST_SHIFT.
- In ST_SHIFT, a rising select with a full shifter takes the "commit" transition to ST_DELIVER. A rising select with a partial shifter takes the "drop" transition back to ST_IDLE.
- ST_DELIVER lasts one cycle. It returns to ST_IDLE ("release"), or goes straight to ST_SHIFT if a new window opens at once ("reopen").

Top module: `serial_cmd_rx`

## Requirements
- R1: After reset, out_valid, out_byte and out_is_data are all 0.
- R2: The first bit clocked in on a serial-clock rising edge while sel_n is low becomes bit 7 of out_byte. Later bits fill bit 6 down to bit 0 in arrival order.
- R3: Each committed byte raises out_valid for exactly one system clock cycle. It rises on the third rising clk edge after sel_n goes high.
- R4: When more than eight serial-clock rising edges occur in one select window, out_byte holds the last eight bits received, MSB first.
- R5: A select window with fewer than eight serial-clock rising edges raises no strobe and leaves out_byte and out_is_data unchanged.
- R6: out_is_data is 0 when rsel was low at the falling edge of sel_n, and 1 when it was high. Changes on rsel while sel_n stays low have no effect on the tag.
- R7: Serial-clock edges while sel_n is high shift in no bits.
- R8: out_byte and out_is_data change only in the cycle in which out_valid rises, and hold between strobes.
- R9: Consecutive select windows separated by three system clock cycles each deliver their own byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Serial select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sdin | input | 1 | Serial data, sampled on the serial clock rising edge |
| rsel | input | 1 | Register select: 0 instruction, 1 data |
| out_byte | output | BYTE_W | Last committed byte |
| out_is_data | output | 1 | Tag of the last committed byte |
| out_valid | output | 1 | One-cycle strobe for a new byte |

## Verification
A bit counter that miscounts shows up at the ports at the closing select edge. Either a strobe is missing, or a strobe appears for a short window, three cycles after sel_n rises. A mis-ordered or stale shifter shows in out_byte in that same strobe cycle. A tag captured at the wrong moment shows in out_is_data only for frames whose rsel changes mid-window, so those frames are driven on purpose. The bench compares a behavioural model against every output on every clock, so any wrong state is reported in the first cycle in which it becomes visible.

// File: rtl/scr_pkg.sv
package scr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SHIFT   = 2'd1,
        ST_DELIVER = 2'd2
    } scr_state_e;

    typedef struct packed {
        logic cs_n;
        logic sck;
        logic sd;
        logic rs;
    } scr_lines_t;

    localparam scr_lines_t LINES_IDLE = '{cs_n: 1'b1, sck: 1'b0, sd: 1'b0, rs: 1'b0};
endpackage

// File: rtl/scr_sync.sv
module scr_sync #(
    parameter int W = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
            else        chain <= {chain[STAGES-2:0], d[g]};
        end
        assign q[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/scr_edge.sv
module scr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_s,
    input  logic sck_s,
    output logic cs_fall,
    output logic cs_rise,
    output logic sck_rise
);
    logic cs_q;
    logic sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q  <= 1'b1;
            sck_q <= 1'b0;
        end else begin
            cs_q  <= cs_n_s;
            sck_q <= sck_s;
        end
    end

    assign cs_fall  = cs_q & ~cs_n_s;
    assign cs_rise  = ~cs_q & cs_n_s;
    assign sck_rise = sck_s & ~sck_q & ~cs_n_s;
endmodule

// File: rtl/scr_shift.sv
module scr_shift #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = $clog2(BYTE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift_en,
    input  logic              din,
    output logic [BYTE_W-1:0] shreg,
    output logic              full
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (clr) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (shift_en) begin
            shreg <= {shreg[BYTE_W-2:0], din};
            if (cnt != CNT_W'(BYTE_W)) cnt <= cnt + 1'b1;
        end
    end

    assign full = (cnt == CNT_W'(BYTE_W));
endmodule

// File: rtl/scr_fsm.sv
module scr_fsm
    import scr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              sck_rise,
    input  logic              rs_s,
    input  logic              full,
    input  logic [BYTE_W-1:0] shreg,
    output logic              clr,
    output logic              shift_en,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_is_data,
    output logic              out_valid
);
    scr_state_e state;
    scr_state_e state_nx;
    logic       rs_cap;
    logic       commit;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (cs_fall) state_nx = ST_SHIFT;
            ST_SHIFT:   if (cs_rise) state_nx = full ? ST_DELIVER : ST_IDLE;
            ST_DELIVER: state_nx = cs_fall ? ST_SHIFT : ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    assign commit   = (state == ST_SHIFT) && cs_rise && full;
    assign clr      = cs_fall;
    assign shift_en = (state == ST_SHIFT) && sck_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_cap      <= 1'b0;
            out_byte    <= '0;
            out_is_data <= 1'b0;
            out_valid   <= 1'b0;
        end else begin
            if (cs_fall) rs_cap <= rs_s;
            out_valid <= commit;
            if (commit) begin
                out_byte    <= shreg;
                out_is_data <= rs_cap;
            end
        end
    end
endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
    import scr_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sclk,
    input  logic              sdin,
    input  logic              rsel,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_is_data,
    output logic              out_valid
);
    localparam int LINE_W = $bits(scr_lines_t);

    scr_lines_t  raw_lines;
    scr_lines_t  syn_lines;
    logic        cs_fall;
    logic        cs_rise;
    logic        sck_rise;
    logic        shift_clr;
    logic        shift_en;
    logic        shift_full;
    logic [BYTE_W-1:0] shreg;

    assign raw_lines = '{cs_n: sel_n, sck: sclk, sd: sdin, rs: rsel};

    scr_sync #(
        .W(LINE_W), .STAGES(SYNC_STAGES), .RST_VAL(LINES_IDLE)
    ) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_lines), .q(syn_lines)
    );

    scr_edge u_edge (
        .clk(clk), .rst_n(rst_n),
        .cs_n_s(syn_lines.cs_n), .sck_s(syn_lines.sck),
        .cs_fall(cs_fall), .cs_rise(cs_rise), .sck_rise(sck_rise)
    );

    scr_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr(shift_clr), .shift_en(shift_en),
        .din(syn_lines.sd), .shreg(shreg), .full(shift_full)
    );

    scr_fsm #(.BYTE_W(BYTE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cs_fall(cs_fall), .cs_rise(cs_rise), .sck_rise(sck_rise),
        .rs_s(syn_lines.rs), .full(shift_full), .shreg(shreg),
        .clr(shift_clr), .shift_en(shift_en),
        .out_byte(out_byte), .out_is_data(out_is_data), .out_valid(out_valid)
    );
endmodule

// File: rtl/scr_checker.sv
module scr_checker #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_n,
    input logic              out_valid,
    input logic              out_is_data,
    input logic [BYTE_W-1:0] out_byte,
    input logic              bit_full
);
    assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_select_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(sel_n, 3));

    assert_full_before_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(bit_full));

    assert_byte_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(out_valid) |-> $stable(out_byte));

    assert_tag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(out_valid) |-> $stable(out_is_data));
endmodule

bind serial_cmd_rx scr_checker #(.BYTE_W(BYTE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .out_valid(out_valid),
    .out_is_data(out_is_data), .out_byte(out_byte), .bit_full(shift_full)
);

// File: tb/tb_serial_cmd_rx.sv
`timescale 1ns/1ps
module tb_serial_cmd_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdin = 1'b0;
    logic       rsel = 1'b0;
    logic [7:0] out_byte;
    logic       out_is_data;
    logic       out_valid;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int strobes = 0;
    int last_rise_cyc = 0;
    int drive_rise_cyc = 0;
    bit wide_pulse = 0;
    bit prev_valid = 0;
    bit done = 0;

    serial_cmd_rx dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdin(sdin),
        .rsel(rsel), .out_byte(out_byte), .out_is_data(out_is_data),
        .out_valid(out_valid)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural reference: raw samples delayed through a history
    bit [3:0] p1 = 4'b1000, p2 = 4'b1000, p3 = 4'b1000; // {cs,sck,sd,rs}
    bit       m_active = 0;
    bit       m_rs = 0;
    bit       m_valid = 0;
    bit [7:0] m_byte = 0;
    bit       m_isdata = 0;
    bit       m_bits[$];

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            p1 = 4'b1000; p2 = 4'b1000; p3 = 4'b1000;
            m_active = 0; m_valid = 0; m_byte = 0; m_isdata = 0; m_bits.delete();
        end else begin
            m_valid = 0;
            if (p3[3] && !p2[3]) begin
                m_active = 1; m_rs = p2[0]; m_bits.delete();
            end else if (!p3[3] && p2[3]) begin
                if (m_active && m_bits.size() >= 8) begin
                    for (int i = 0; i < 8; i++)
                        m_byte[7-i] = m_bits[m_bits.size() - 8 + i];
                    m_isdata = m_rs;
                    m_valid = 1;
                end
                m_active = 0;
            end else if (m_active && !p2[3] && !p3[2] && p2[2]) begin
                m_bits.push_back(p2[1]);
            end
            p3 = p2; p2 = p1; p1 = {sel_n, sclk, sdin, rsel};
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(out_valid == m_valid, "R3 model strobe", out_valid, m_valid);
            check(out_byte == m_byte, "R2 model byte", out_byte, m_byte);
            check(out_is_data == m_isdata, "R6 model tag", out_is_data, m_isdata);
            if (out_valid && !prev_valid) begin
                strobes++;
                last_rise_cyc = cyc;
            end
            if (out_valid && prev_valid) wide_pulse = 1;
            prev_valid = out_valid;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input bit rs, input logic [31:0] bits, input int n,
                         input bit flip_rs);
        rsel = rs;
        wait_cyc(3);
        sel_n = 1'b0;
        wait_cyc(3);
        if (flip_rs) rsel = ~rs;
        for (int i = n - 1; i >= 0; i--) begin
            sclk = 1'b0; sdin = bits[i];
            wait_cyc(3);
            sclk = 1'b1;
            wait_cyc(3);
        end
        sclk = 1'b0;
        wait_cyc(3);
        sel_n = 1'b1;
        drive_rise_cyc = cyc;
        wait_cyc(8);
    endtask

    initial begin
        int s0;
        wait_cyc(4);
        check(out_valid == 0 && out_byte == 0 && out_is_data == 0, "R1 reset",
              {out_valid, out_is_data, out_byte}, 0);
        rst_n = 1'b1;
        wait_cyc(4);

        s0 = strobes;
        frame(1'b0, 32'hA5, 8, 0);
        check(strobes == s0 + 1, "R2 strobe count", strobes, s0 + 1);
        check(out_byte == 8'hA5, "R2 msb first", out_byte, 8'hA5);
        check(out_is_data == 0, "R6 instruction tag", out_is_data, 0);
        check(last_rise_cyc - drive_rise_cyc == 3, "R3 latency",
              last_rise_cyc - drive_rise_cyc, 3);

        frame(1'b1, 32'h3C, 8, 0);
        check(out_byte == 8'h3C && out_is_data == 1, "R6 data tag",
              {out_is_data, out_byte}, 9'h13C);

        frame(1'b0, 32'hF5A, 12, 0);
        check(out_byte == 8'h5A, "R4 last eight", out_byte, 8'h5A);

        s0 = strobes;
        frame(1'b1, 32'h1F, 5, 0);
        check(strobes == s0, "R5 no strobe", strobes, s0);
        check(out_byte == 8'h5A && out_is_data == 0, "R5 outputs kept",
              {out_is_data, out_byte}, 9'h05A);

        frame(1'b1, 32'hC3, 8, 1);
        check(out_is_data == 1 && out_byte == 8'hC3, "R6 tag at select fall",
              {out_is_data, out_byte}, 9'h1C3);

        sdin = 1'b1;
        for (int k = 0; k < 5; k++) begin
            sclk = 1'b1; wait_cyc(3); sclk = 1'b0; wait_cyc(3);
        end
        s0 = strobes;
        check(strobes == s0 && out_byte == 8'hC3, "R7 idle clocks", out_byte, 8'hC3);
        frame(1'b0, 32'h00, 8, 0);
        check(out_byte == 8'h00, "R7 no stray bits", out_byte, 8'h00);

        // back-to-back windows with a three-cycle gap
        s0 = strobes;
        rsel = 1'b0; sel_n = 1'b0; wait_cyc(3);
        for (int i = 7; i >= 0; i--) begin
            sdin = 8'h81 >> i; sclk = 1'b0; wait_cyc(3); sclk = 1'b1; wait_cyc(3);
        end
        sclk = 1'b0; wait_cyc(3);
        sel_n = 1'b1; rsel = 1'b1; wait_cyc(3);
        sel_n = 1'b0; wait_cyc(3);
        for (int i = 7; i >= 0; i--) begin
            sdin = 8'h7E >> i; sclk = 1'b0; wait_cyc(3); sclk = 1'b1; wait_cyc(3);
        end
        sclk = 1'b0; wait_cyc(3);
        sel_n = 1'b1; wait_cyc(8);
        check(strobes == s0 + 2, "R9 both delivered", strobes, s0 + 2);
        check(out_byte == 8'h7E && out_is_data == 1, "R9 second byte",
              {out_is_data, out_byte}, 9'h17E);
        check(wide_pulse == 0, "R3 pulse width", wide_pulse, 0);
        check(out_valid == 0, "R8 quiet after strobe", out_valid, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule